// File: doc/BRIEF.md
# E1 Timeslot-0 Transmit Octet Generator

This block builds the timeslot-0 octet that leads every outgoing E1 frame. One pulse on the frame strobe issues the next frame. The octet for that frame is registered on the following clock edge, together with its frame number (0 to 15) and a multiframe number. In normal operation the octet carries the frame alignment word on even frames. On odd frames it carries the non-alignment pattern, taken from static pattern inputs. A transparent override can replace the whole octet with a byte from channel 0 or from an alternating RAM buffer.

With CRC-4 framing enabled, the leading bit of each octet takes one of several roles. On frames 1 to 11 it carries the multiframe alignment sequence. On even frames it carries the four check bits of the previous submultiframe. On frames 13 and 15 it carries either static spare bits or remote-error E-bits, and the polarity of the E-bits can be selected. The check bits are computed inside the block. They cover the timeslot-0 octet as sent and the other timeslots' octets, which arrive on a byte input during the frame. Remote-error reports from the receive side are collected over one multiframe and are sent in the next.

Bit 7 of every octet is the first bit on the line (bit 1 of the frame).

Top module: `e1_ts0_tx_gen`

## Requirements
- R1: After synchronous reset, ts0_byte is 0xFF, frame_num is 15 and mf_num is all ones. The first strobe therefore issues frame 0 of multiframe 0.
- R2: Each frame_stb advances frame_num by one, wrapping 15 to 0, and mf_num rises by one whenever frame 0 is issued. The new ts0_byte appears one clock after the strobe. Between strobes, all three outputs hold.
- R3: In doubleframe mode (cfg_reg[0]=0, cfg_reg[1]=0), an even frame sends {pat_even_si, 0011011}. An odd frame sends {pat_odd[6], 1, pat_odd[5:0]}, where pat_odd[5] is the A bit and pat_odd[4:0] are the five Sa bits.
- R4: When cfg_reg[1]=1 (transparent), the octet is ch0_byte if cfg_reg[2]=0 and ram_byte if cfg_reg[2]=1. The pattern inputs and the framing are ignored.
- R5: In CRC-4 mode (cfg_reg[0]=1), bit 7 of frames 1, 3, 5, 7, 9 and 11 is 0, 0, 1, 0, 1, 1 respectively. Bits 6..0 of odd frames are {1, pat_odd[5:0]}.
- R6: In CRC-4 mode, bit 7 of even frames carries a check bit and bits 6..0 are 0011011. Frames 0, 2, 4 and 6 carry C1..C4 of the submultiframe made of frames 8 to 15 just before. Frames 8, 10, 12 and 14 carry C1..C4 of frames 0 to 7.
- R7: The check value is the remainder of the message times x^4, divided by x^4+x+1, with C1 as its most significant bit. The message is each frame's octet as sent, with bit 7 cleared on even frames, followed by the pay_byte octets accepted in that frame, all MSB first. pay_vld is ignored in a strobe cycle.
- R8: In CRC-4 mode with cfg_reg[3]=0, bit 7 of frame 13 is cfg_reg[5] and bit 7 of frame 15 is cfg_reg[6].
- R9: In CRC-4 mode with cfg_reg[3]=1, bit 7 of frame 13 (frame 15) is 0 if an rx_err_smf1 (rx_err_smf2) pulse arrived during the previous multiframe, and 1 otherwise. The result is inverted when cfg_reg[4]=1. A pulse in the strobe cycle that issues frame 0 belongs to the new multiframe.
- R10: In doubleframe mode, frames 13 and 15 carry pat_odd[6] like any odd frame, whatever the spare-bit and E-bit controls are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse that issues the next frame |
| cfg_reg | input | 7 | [0] CRC-4 mode, [1] transparent, [2] RAM source, [3] automatic E-bits, [4] invert E-bits, [5] spare bit of frame 13, [6] spare bit of frame 15 |
| pat_even_si | input | 1 | International bit for even frames in doubleframe mode |
| pat_odd | input | 7 | [6] international bit, [5] A bit, [4:0] Sa bits for odd frames |
| ch0_byte | input | 8 | Channel-0 byte for transparent mode |
| ram_byte | input | 8 | Alternating RAM buffer byte for transparent mode |
| pay_vld | input | 1 | pay_byte is valid this cycle |
| pay_byte | input | 8 | Octet of another timeslot of the current frame, for the check sum |
| rx_err_smf1 | input | 1 | Receive check error reported for submultiframe I |
| rx_err_smf2 | input | 1 | Receive check error reported for submultiframe II |
| ts0_byte | output | 8 | Timeslot-0 octet, bit 7 sent first |
| frame_num | output | 4 | Frame number of the octet on ts0_byte |
| mf_num | output | MF_W | Multiframe number of the octet on ts0_byte |

## Verification
The octet, frame number and multiframe number of an issued frame are due one clock after the strobe. The bench drives each strobe on a falling edge and samples on the next falling edge, one rising edge later. Check bits are due one submultiframe late and E-bits one multiframe late. The bench's reference model therefore stores the remainder of each finished submultiframe, and each error report seen during a multiframe, until the frame that must carry it is issued.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;

    localparam int FRAMES_PER_MF = 16;
    localparam int FN_W          = $clog2(FRAMES_PER_MF);
    localparam int SMF_PER_MF    = 2;
    localparam int OCT_W         = 8;
    localparam int CRC_W         = 4;
    localparam int CFG_W         = 7;
    localparam logic [CRC_W-1:0] CRC_POLY  = 4'b0011;      // x^4 + x + 1, x^4 implied
    localparam logic [OCT_W-2:0] ALIGN_WORD = 7'b0011011;
    localparam logic [OCT_W-1:0] IDLE_OCT   = 8'hFF;

    typedef struct packed {
        logic xs15;
        logic xs13;
        logic e_neg;
        logic e_auto;
        logic src_ram;
        logic transp;
        logic crc4;
    } ts0_cfg_t;

    typedef enum logic [1:0] {
        OCT_ALIGN,
        OCT_SERVICE,
        OCT_PASS
    } oct_kind_e;

    // Fold one octet, MSB first, into the running remainder.
    function automatic logic [CRC_W-1:0] crc4_step(input logic [CRC_W-1:0] c,
                                                   input logic [OCT_W-1:0] b);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = OCT_W - 1; i >= 0; i--) begin
            fb = b[i] ^ r[CRC_W-1];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction

    // Multiframe alignment bit for odd frames 1..11.
    function automatic logic mf_align_bit(input logic [FN_W-1:0] fn);
        logic v;
        case (fn)
            4'd5, 4'd9, 4'd11: v = 1'b1;
            default:           v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/e1_ts0_seq.sv
module e1_ts0_seq
    import e1_ts0_pkg::*;
#(
    parameter int MF_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stb,
    output logic [FN_W-1:0] frame_num,
    output logic [MF_W-1:0] mf_num,
    output logic [FN_W-1:0] issue_fn,
    output logic            issue_mf_start,
    output logic            issue_smf_start
);

    assign issue_fn        = frame_num + FN_W'(1);
    assign issue_mf_start  = (issue_fn == '0);
    assign issue_smf_start = (issue_fn[FN_W-2:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_num <= '1;
            mf_num    <= '1;
        end else if (stb) begin
            frame_num <= issue_fn;
            if (issue_mf_start)
                mf_num <= mf_num + MF_W'(1);
        end
    end

endmodule

// File: rtl/e1_ts0_crc.sv
module e1_ts0_crc
    import e1_ts0_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             smf_start,
    input  logic [OCT_W-1:0] sent_oct,
    input  logic             pay_vld,
    input  logic [OCT_W-1:0] pay_byte,
    output logic [CRC_W-1:0] c_bits
);

    logic [CRC_W-1:0] acc;
    logic [CRC_W-1:0] held;

    // At a submultiframe boundary the finished remainder is used directly.
    assign c_bits = smf_start ? acc : held;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            held <= '0;
        end else if (stb) begin
            if (smf_start) begin
                held <= acc;
                acc  <= crc4_step('0, sent_oct);
            end else begin
                acc  <= crc4_step(acc, sent_oct);
            end
        end else if (pay_vld) begin
            acc <= crc4_step(acc, pay_byte);
        end
    end

endmodule

// File: rtl/e1_ts0_ebit.sv
module e1_ts0_ebit
    import e1_ts0_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stb,
    input  logic                  mf_start,
    input  logic [SMF_PER_MF-1:0] err_smf,
    output logic [SMF_PER_MF-1:0] e_err
);

    logic [SMF_PER_MF-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            e_err <= '0;
        end else if (stb && mf_start) begin
            e_err <= pend;
            pend  <= err_smf;
        end else begin
            pend  <= pend | err_smf;
        end
    end

endmodule

// File: rtl/e1_ts0_octet.sv
module e1_ts0_octet
    import e1_ts0_pkg::*;
(
    input  ts0_cfg_t              cfg,
    input  logic [FN_W-1:0]       fn,
    input  logic                  pat_even_si,
    input  logic [OCT_W-2:0]      pat_odd,
    input  logic [OCT_W-1:0]      ch0_byte,
    input  logic [OCT_W-1:0]      ram_byte,
    input  logic [CRC_W-1:0]      c_bits,
    input  logic [SMF_PER_MF-1:0] e_err,
    output logic [OCT_W-1:0]      oct,
    output logic [OCT_W-1:0]      oct_crc
);

    oct_kind_e kind;
    logic      c_sel;
    logic      lead_odd;
    logic [SMF_PER_MF-1:0] e_line;

    assign e_line = ~e_err ^ {SMF_PER_MF{cfg.e_neg}};

    always_comb begin
        if (cfg.transp)
            kind = OCT_PASS;
        else if (fn[0])
            kind = OCT_SERVICE;
        else
            kind = OCT_ALIGN;
    end

    always_comb begin
        case (fn[2:1])
            2'd0:    c_sel = c_bits[3];
            2'd1:    c_sel = c_bits[2];
            2'd2:    c_sel = c_bits[1];
            default: c_sel = c_bits[0];
        endcase
    end

    always_comb begin
        if (!cfg.crc4)
            lead_odd = pat_odd[OCT_W-2];
        else if (fn == 4'd13)
            lead_odd = cfg.e_auto ? e_line[0] : cfg.xs13;
        else if (fn == 4'd15)
            lead_odd = cfg.e_auto ? e_line[1] : cfg.xs15;
        else
            lead_odd = mf_align_bit(fn);
    end

    always_comb begin
        case (kind)
            OCT_PASS:    oct = cfg.src_ram ? ram_byte : ch0_byte;
            OCT_SERVICE: oct = {lead_odd, 1'b1, pat_odd[OCT_W-3:0]};
            default:     oct = {cfg.crc4 ? c_sel : pat_even_si, ALIGN_WORD};
        endcase
        oct_crc = oct;
        if (!fn[0])
            oct_crc[OCT_W-1] = 1'b0;
    end

endmodule

// File: rtl/e1_ts0_tx_gen.sv
module e1_ts0_tx_gen
    import e1_ts0_pkg::*;
#(
    parameter int MF_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_stb,
    input  logic [6:0]      cfg_reg,
    input  logic            pat_even_si,
    input  logic [6:0]      pat_odd,
    input  logic [7:0]      ch0_byte,
    input  logic [7:0]      ram_byte,
    input  logic            pay_vld,
    input  logic [7:0]      pay_byte,
    input  logic            rx_err_smf1,
    input  logic            rx_err_smf2,
    output logic [7:0]      ts0_byte,
    output logic [3:0]      frame_num,
    output logic [MF_W-1:0] mf_num
);

    ts0_cfg_t              cfg;
    logic [FN_W-1:0]       issue_fn;
    logic                  issue_mf_start;
    logic                  issue_smf_start;
    logic [CRC_W-1:0]      c_bits;
    logic [SMF_PER_MF-1:0] e_err;
    logic [OCT_W-1:0]      oct;
    logic [OCT_W-1:0]      oct_crc;

    assign cfg = ts0_cfg_t'(cfg_reg);

    e1_ts0_seq #(.MF_W(MF_W)) u_seq (
        .clk             (clk),
        .rst             (rst),
        .stb             (frame_stb),
        .frame_num       (frame_num),
        .mf_num          (mf_num),
        .issue_fn        (issue_fn),
        .issue_mf_start  (issue_mf_start),
        .issue_smf_start (issue_smf_start)
    );

    e1_ts0_crc u_crc (
        .clk       (clk),
        .rst       (rst),
        .stb       (frame_stb),
        .smf_start (issue_smf_start),
        .sent_oct  (oct_crc),
        .pay_vld   (pay_vld),
        .pay_byte  (pay_byte),
        .c_bits    (c_bits)
    );

    e1_ts0_ebit u_ebit (
        .clk      (clk),
        .rst      (rst),
        .stb      (frame_stb),
        .mf_start (issue_mf_start),
        .err_smf  ({rx_err_smf2, rx_err_smf1}),
        .e_err    (e_err)
    );

    e1_ts0_octet u_oct (
        .cfg         (cfg),
        .fn          (issue_fn),
        .pat_even_si (pat_even_si),
        .pat_odd     (pat_odd),
        .ch0_byte    (ch0_byte),
        .ram_byte    (ram_byte),
        .c_bits      (c_bits),
        .e_err       (e_err),
        .oct         (oct),
        .oct_crc     (oct_crc)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ts0_byte <= IDLE_OCT;
        else if (frame_stb)
            ts0_byte <= oct;
    end

endmodule

// File: rtl/e1_ts0_tx_gen_chk.sv
module e1_ts0_tx_gen_chk #(
    parameter int MF_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            frame_stb,
    input logic [6:0]      cfg_reg,
    input logic [7:0]      ch0_byte,
    input logic [7:0]      ram_byte,
    input logic [7:0]      ts0_byte,
    input logic [3:0]      frame_num,
    input logic [MF_W-1:0] mf_num
);

    a_r2_frame_step: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> frame_num == $past(frame_num) + 4'd1);

    a_r2_mf_step: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && frame_num == 4'd15) |=> mf_num == $past(mf_num) + MF_W'(1));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> ($stable(ts0_byte) && $stable(frame_num) && $stable(mf_num)));

    a_r4_pass_ch0: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && cfg_reg[1] && !cfg_reg[2]) |=> ts0_byte == $past(ch0_byte));

    a_r4_pass_ram: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && cfg_reg[1] && cfg_reg[2]) |=> ts0_byte == $past(ram_byte));

    a_r3_align_word: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !cfg_reg[1] && frame_num[0]) |=> ts0_byte[6:0] == 7'b0011011);

    a_r3_service_bit: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !cfg_reg[1] && !frame_num[0]) |=> ts0_byte[6]);

    a_r5_mfas_f1: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && cfg_reg[0] && !cfg_reg[1] && frame_num == 4'd0) |=> !ts0_byte[7]);

    a_r5_mfas_f5: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && cfg_reg[0] && !cfg_reg[1] && frame_num == 4'd4) |=> ts0_byte[7]);

endmodule

bind e1_ts0_tx_gen e1_ts0_tx_gen_chk #(.MF_W(MF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .cfg_reg   (cfg_reg),
    .ch0_byte  (ch0_byte),
    .ram_byte  (ram_byte),
    .ts0_byte  (ts0_byte),
    .frame_num (frame_num),
    .mf_num    (mf_num)
);

// File: tb/tb_e1_ts0_tx_gen.sv
module tb_e1_ts0_tx_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 1'b0;
    logic [6:0] cfg_reg = '0;
    logic       pat_even_si = 1'b0;
    logic [6:0] pat_odd = '0;
    logic [7:0] ch0_byte = '0;
    logic [7:0] ram_byte = '0;
    logic       pay_vld = 1'b0;
    logic [7:0] pay_byte = '0;
    logic       rx_err_smf1 = 1'b0;
    logic       rx_err_smf2 = 1'b0;
    logic [7:0] ts0_byte;
    logic [3:0] frame_num;
    logic [7:0] mf_num;

    int nvec = 0;
    int nfail = 0;
    logic msgq[$];

    always #4 clk = ~clk;

    e1_ts0_tx_gen #(.MF_W(8)) dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .cfg_reg(cfg_reg),
        .pat_even_si(pat_even_si), .pat_odd(pat_odd), .ch0_byte(ch0_byte),
        .ram_byte(ram_byte), .pay_vld(pay_vld), .pay_byte(pay_byte),
        .rx_err_smf1(rx_err_smf1), .rx_err_smf2(rx_err_smf2),
        .ts0_byte(ts0_byte), .frame_num(frame_num), .mf_num(mf_num)
    );

    // {cfg, even si (bit0), odd pattern, ch0, ram, expected octet}; entry i is frame i
    localparam logic [47:0] VEC [16] = '{
        48'h00_01_00_00_00_9B,  // R3 even, si=1
        48'h00_00_15_00_00_55,  // R3 odd
        48'h00_00_00_00_00_1B,  // R3 even, si=0
        48'h00_00_7F_00_00_FF,  // R3 odd, all ones
        48'h02_01_7F_A5_3C_A5,  // R4 channel 0
        48'h06_01_7F_A5_3C_3C,  // R4 RAM
        48'h01_01_00_00_00_1B,  // R6 C4 of empty history is 0
        48'h01_00_6A_00_00_6A,  // R5 frame 7 -> 0
        48'h00_01_00_00_00_9B,  // R3
        48'h01_00_00_00_00_C0,  // R5 frame 9 -> 1
        48'h02_00_00_5A_00_5A,  // R4
        48'h01_00_3F_00_00_FF,  // R5 frame 11 -> 1
        48'h00_00_00_00_00_1B,  // R3
        48'h21_00_00_00_00_C0,  // R8 xs13 = 1
        48'h00_01_00_00_00_9B,  // R3
        48'h01_00_01_00_00_41   // R8 xs15 = 0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        frame_stb = 1'b0;
        pay_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue(input logic [6:0] c, input logic pe, input logic [6:0] po,
                         input logic [7:0] c0, input logic [7:0] rb, input logic junk);
        @(negedge clk);
        cfg_reg = c;
        pat_even_si = pe;
        pat_odd = po;
        ch0_byte = c0;
        ram_byte = rb;
        frame_stb = 1'b1;
        pay_vld = junk;
        pay_byte = 8'hEE;
        @(negedge clk);
        frame_stb = 1'b0;
        pay_vld = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b);
        @(negedge clk);
        pay_vld = 1'b1;
        pay_byte = b;
        @(negedge clk);
        pay_vld = 1'b0;
    endtask

    task automatic pulse_err(input logic e1, input logic e2);
        @(negedge clk);
        rx_err_smf1 = e1;
        rx_err_smf2 = e2;
        @(negedge clk);
        rx_err_smf1 = 1'b0;
        rx_err_smf2 = 1'b0;
    endtask

    task automatic push_oct(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) msgq.push_back(b[i]);
    endtask

    // Long division of (message * x^4) by 10011.
    function automatic logic [3:0] model_rem();
        logic [3:0] r = 4'd0;
        logic [4:0] r5;
        logic b;
        for (int i = 0; i < msgq.size() + 4; i++) begin
            b = (i < msgq.size()) ? msgq[i] : 1'b0;
            r5 = {r, b};
            if (r5[4]) r5 = r5 ^ 5'b10011;
            r = r5[3:0];
        end
        return r;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] cur_c;
        logic [1:0] e_pend;
        logic [1:0] e_act;
        logic [7:0] exp;
        logic [6:0] cf;
        logic [6:0] po;
        logic lead;

        // R1 reset state
        do_reset();
        chk("R1 reset octet", ts0_byte, 8'hFF);
        chk("R1 reset frame", frame_num, 4'hF);
        chk("R1 reset multiframe", mf_num, 8'hFF);

        // Table walk: frames 0..15 of multiframe 0
        for (int i = 0; i < 16; i++) begin
            issue(VEC[i][46:40], VEC[i][32], VEC[i][30:24], VEC[i][23:16], VEC[i][15:8], 1'b0);
            chk("R2 frame number", frame_num, i);
            chk("R3/R4/R5/R6/R8 table octet", ts0_byte, VEC[i][7:0]);
            if (i == 0) chk("R1 first multiframe", mf_num, 8'd0);
        end
        issue(7'h00, 1'b1, 7'h00, 8'h00, 8'h00, 1'b0);
        chk("R2 wrap frame", frame_num, 4'd0);
        chk("R2 multiframe step", mf_num, 8'd1);
        chk("R3 after wrap", ts0_byte, 8'h9B);
        // R2 hold between strobes
        repeat (3) @(negedge clk);
        chk("R2 hold octet", ts0_byte, 8'h9B);
        chk("R2 hold frame", frame_num, 4'd0);

        // R10: doubleframe ignores spare and E-bit controls
        for (int f = 1; f < 13; f++) issue(7'h00, 1'b0, 7'h00, 8'h00, 8'h00, 1'b0);
        issue(7'h78, 1'b0, 7'h00, 8'h00, 8'h00, 1'b0);
        chk("R10 frame 13 doubleframe", ts0_byte, 8'h40);

        // CRC-4 and E-bit run over three multiframes
        do_reset();
        msgq.delete();
        cur_c = 4'd0;
        e_pend = 2'b00;
        e_act = 2'b00;
        for (int m = 0; m < 3; m++) begin
            cf = (m == 2) ? 7'h19 : 7'h09;
            for (int f = 0; f < 16; f++) begin
                po = 7'h40 | 7'((f * 3) & 63);
                if (f == 0) begin
                    e_act = e_pend;
                    e_pend = 2'b00;
                end
                if (f == 0 || f == 8) begin
                    cur_c = model_rem();
                    msgq.delete();
                end
                if (f % 2 == 0) begin
                    exp = {cur_c[3 - ((f / 2) % 4)], 7'b0011011};
                end else begin
                    if (f == 13)      lead = ~e_act[0] ^ cf[4];
                    else if (f == 15) lead = ~e_act[1] ^ cf[4];
                    else              lead = (f == 5 || f == 9 || f == 11);
                    exp = {lead, 1'b1, po[5:0]};
                end
                issue(cf, 1'b1, po, 8'h00, 8'h00, f == 4);
                if (f % 2 == 0)
                    chk("R6 R7 check-bit octet", ts0_byte, exp);
                else if (f == 13 || f == 15)
                    chk("R9 E-bit octet", ts0_byte, exp);
                else
                    chk("R5 alignment octet", ts0_byte, exp);
                push_oct((f % 2 == 0) ? {1'b0, exp[6:0]} : exp);
                for (int k = 0; k < 3; k++) begin
                    feed(8'((f * 37 + m * 11 + k * 5) & 255));
                    push_oct(8'((f * 37 + m * 11 + k * 5) & 255));
                end
                if (m == 0 && f == 2) begin
                    pulse_err(1'b1, 1'b0);
                    e_pend[0] = 1'b1;
                end
                if (m == 1 && f == 5) begin
                    pulse_err(1'b0, 1'b1);
                    e_pend[1] = 1'b1;
                end
            end
        end
        // Next multiframe frame 0 carries C1 of the last submultiframe
        cur_c = model_rem();
        issue(7'h09, 1'b1, 7'h00, 8'h00, 8'h00, 1'b0);
        chk("R6 R7 final C1", ts0_byte, {cur_c[3], 7'b0011011});
        chk("R2 multiframe count", mf_num, 8'd3);

        summary();
        $finish;
    end

endmodule